// File: doc/BRIEF.md
# Interlaced Vertical Timing and Composite Sync Generator

This block produces the vertical half of a 525-line interlaced video timing chain. It advances once per half-line strobe, which is a one-cycle pulse at twice the line rate, and counts 525 half-lines per field. At the end of each field it toggles a field flag, so two fields make one frame and the second field starts half a line later than the first. From the half-line position it decodes several outputs: a 3H vertical pulse, a vertical blanking window whose length is selectable, and a burst-enable mask that is low for the first 9H of every field. It also produces a composite sync output by choosing, for each half-line, one of three pulse shapes that the horizontal decoder supplies.

Those three shapes are the normal line sync, the narrow equalizing pulse (about 2.23 us) and the serration pulse. The serration pulse is high for the half-line minus the line-sync width. The first 3H of each field carries equalizing pulses, the next 3H carries serrated vertical sync, and a further 3H of equalizing pulses follows. After that, line sync passes only on half-lines that begin a line.

An external vertical reset input idles high. It is synchronized, and a falling edge on it is detected. The half-line strobe that follows such an edge loads the counter to the start of the vertical pulse, so the vertical pulse begins on that strobe. A phase output records whether each reset edge came before the vertical pulse in the field or after it.

Top module: `vsync_gen`

## Requirements
- R1: The half-line index (0 to 524) advances by one on each `halfStrobe` and otherwise holds. After 524 it returns to 0, and `fieldOut` toggles at that moment.
- R2: `vpOut` is high exactly on half-lines 6 to 11, which is 3H.
- R3: On half-lines 0 to 5 and 12 to 17, `syncOut` equals `eqIn`. On half-lines 6 to 11, `syncOut` equals `serIn`.
- R4: On half-lines 18 and above, `syncOut` equals `hSyncIn` on half-lines that start a line and is 0 on the others. A half-line starts a line when its index is even while `fieldOut`=0, or odd while `fieldOut`=1.
- R5: `burstEn` is 0 on half-lines 0 to 17 (9H) and 1 from half-line 18 onward.
- R6: `vBlankOut` is high while the half-line index is below twice N lines. N is 19, 20, 21 and 21 for `blkSel` = 00, 01, 10 and 11.
- R7: `vrIn` passes through two synchronizer flops before edge detection. A detected falling edge makes the next `halfStrobe` load half-line 6 instead of incrementing, and leaves `fieldOut` unchanged. `vpOut` is therefore high from that strobe onward. A rising edge has no effect.
- R8: When a falling edge of `vrIn` is detected, `phaseLead` becomes 1 if the half-line index is below 6 (the edge leads the vertical pulse) and 0 otherwise (it trails). Between detected falling edges `phaseLead` holds its value.
- R9: While `rstN` is low, the half-line index is 0, `fieldOut` is 0, `phaseLead` is 0 and no realignment is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfStrobe | input | 1 | One-cycle pulse at each half-line boundary (2fH) |
| hSyncIn | input | 1 | Line sync shape for the current half-line |
| eqIn | input | 1 | Equalizing pulse shape for the current half-line |
| serIn | input | 1 | Serration pulse shape for the current half-line |
| vrIn | input | 1 | Vertical reset, idles high; a falling edge realigns the counter |
| blkSel | input | 2 | Selects the vertical blanking length |
| syncOut | output | 1 | Composite sync, active high |
| vpOut | output | 1 | Vertical pulse, 3H |
| vBlankOut | output | 1 | Vertical blanking window |
| burstEn | output | 1 | Low where the burst flag must be removed |
| fieldOut | output | 1 | Field flag |
| phaseLead | output | 1 | 1 when the reset edge led the vertical pulse |

## Verification
The decoded outputs are combinational functions of the registered half-line index. They change one clock edge after the `halfStrobe` cycle. The bench pulses the strobe for one cycle, then samples two or more falling edges later, when the index has settled. A reset edge on `vrIn` reaches `phaseLead` on the third rising edge after the input changes (two synchronizer flops, then the edge register), so the bench waits four cycles before it checks the phase. The realignment itself appears only after the next strobe, and the bench checks `vpOut` after that strobe.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  typedef struct packed {
    logic advance;
    logic realign;
  } vStrobe_t;
endpackage

// File: rtl/vsync_ctrl.sv
module vsync_ctrl #(
  parameter int HALF_PER_FIELD = 525,
  parameter int VP_START       = 6,
  localparam int CW            = $clog2(HALF_PER_FIELD)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    halfStrobe,
  input  logic                    vrIn,
  input  logic [CW-1:0]           halfIdx,
  output vsync_pkg::vStrobe_t     strobe,
  output logic                    phaseLead
);
  logic vrMeta, vrSync, vrPrev, vrFall, pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vrMeta <= 1'b1;
      vrSync <= 1'b1;
      vrPrev <= 1'b1;
    end else begin
      vrMeta <= vrIn;
      vrSync <= vrMeta;
      vrPrev <= vrSync;
    end
  end

  assign vrFall = vrPrev & ~vrSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      phaseLead <= 1'b0;
    end else begin
      pending <= (pending & ~halfStrobe) | vrFall;
      if (vrFall) phaseLead <= (halfIdx < CW'(VP_START));
    end
  end

  assign strobe.advance = halfStrobe;
  assign strobe.realign = halfStrobe & pending;

  a_r8_phase_holds: assert property (@(posedge clk) disable iff (!rstN)
    !vrFall |=> $stable(phaseLead));
  a_r8_phase_value: assert property (@(posedge clk) disable iff (!rstN)
    vrFall |=> phaseLead == ($past(halfIdx) < CW'(VP_START)));
endmodule

// File: rtl/vsync_datapath.sv
module vsync_datapath #(
  parameter int HALF_PER_FIELD = 525,
  parameter int EQ_HALVES      = 6,
  parameter int VS_HALVES      = 6,
  parameter int VBLANK_BASE    = 19,
  localparam int CW            = $clog2(HALF_PER_FIELD),
  localparam int VS_START      = EQ_HALVES,
  localparam int VS_END        = EQ_HALVES + VS_HALVES,
  localparam int EQ2_END       = VS_END + EQ_HALVES
) (
  input  logic                clk,
  input  logic                rstN,
  input  vsync_pkg::vStrobe_t strobe,
  input  logic [1:0]          blkSel,
  input  logic                hSyncIn,
  input  logic                eqIn,
  input  logic                serIn,
  output logic [CW-1:0]       halfIdx,
  output logic                fieldOut,
  output logic                syncOut,
  output logic                vpOut,
  output logic                vBlankOut,
  output logic                burstEn
);
  logic atLast, inEq, inVs, lineStart;
  logic [CW:0] blankHalves;

  assign atLast = (halfIdx == CW'(HALF_PER_FIELD - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfIdx  <= '0;
      fieldOut <= 1'b0;
    end else if (strobe.realign) begin
      halfIdx <= CW'(VS_START);
    end else if (strobe.advance) begin
      if (atLast) begin
        halfIdx  <= '0;
        fieldOut <= ~fieldOut;
      end else begin
        halfIdx <= halfIdx + 1'b1;
      end
    end
  end

  always_comb begin
    case (blkSel)
      2'b00:   blankHalves = (CW+1)'(2 * VBLANK_BASE);
      2'b01:   blankHalves = (CW+1)'(2 * (VBLANK_BASE + 1));
      default: blankHalves = (CW+1)'(2 * (VBLANK_BASE + 2));
    endcase
  end

  assign inVs      = (halfIdx >= CW'(VS_START)) && (halfIdx < CW'(VS_END));
  assign inEq      = (halfIdx < CW'(EQ2_END)) && !inVs;
  assign lineStart = (halfIdx[0] == fieldOut);
  assign vpOut     = inVs;
  assign burstEn   = (halfIdx >= CW'(EQ2_END));
  assign vBlankOut = ({1'b0, halfIdx} < blankHalves);

  always_comb begin
    if (inVs)           syncOut = serIn;
    else if (inEq)      syncOut = eqIn;
    else if (lineStart) syncOut = hSyncIn;
    else                syncOut = 1'b0;
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(halfIdx) && $stable(fieldOut));
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.realign && atLast) |=> (halfIdx == '0) && (fieldOut != $past(fieldOut)));
  a_r7_realign_vp: assert property (@(posedge clk) disable iff (!rstN)
    strobe.realign |=> vpOut && $stable(fieldOut));
  a_r5_no_burst_in_vp: assert property (@(posedge clk) disable iff (!rstN)
    vpOut |-> !burstEn);
  a_r6_blank_covers_vp: assert property (@(posedge clk) disable iff (!rstN)
    vpOut |-> vBlankOut);
endmodule

// File: rtl/vsync_gen.sv
module vsync_gen #(
  parameter int HALF_PER_FIELD = 525,
  parameter int EQ_HALVES      = 6,
  parameter int VS_HALVES      = 6,
  parameter int VBLANK_BASE    = 19,
  localparam int CW            = $clog2(HALF_PER_FIELD)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       halfStrobe,
  input  logic       hSyncIn,
  input  logic       eqIn,
  input  logic       serIn,
  input  logic       vrIn,
  input  logic [1:0] blkSel,
  output logic       syncOut,
  output logic       vpOut,
  output logic       vBlankOut,
  output logic       burstEn,
  output logic       fieldOut,
  output logic       phaseLead
);
  vsync_pkg::vStrobe_t strobe;
  logic [CW-1:0] halfIdx;

  vsync_ctrl #(.HALF_PER_FIELD(HALF_PER_FIELD), .VP_START(EQ_HALVES)) u_ctrl (
    .clk(clk), .rstN(rstN), .halfStrobe(halfStrobe), .vrIn(vrIn),
    .halfIdx(halfIdx), .strobe(strobe), .phaseLead(phaseLead)
  );

  vsync_datapath #(.HALF_PER_FIELD(HALF_PER_FIELD), .EQ_HALVES(EQ_HALVES),
                   .VS_HALVES(VS_HALVES), .VBLANK_BASE(VBLANK_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blkSel(blkSel),
    .hSyncIn(hSyncIn), .eqIn(eqIn), .serIn(serIn), .halfIdx(halfIdx),
    .fieldOut(fieldOut), .syncOut(syncOut), .vpOut(vpOut),
    .vBlankOut(vBlankOut), .burstEn(burstEn)
  );
endmodule

// File: tb/vsync_gen_bench.sv
module vsync_gen_bench;
  logic clk = 1'b0, rstN = 1'b0, halfStrobe = 1'b0;
  logic hSyncIn = 1'b0, eqIn = 1'b0, serIn = 1'b0, vrIn = 1'b1;
  logic [1:0] blkSel = 2'b00;
  logic syncOut, vpOut, vBlankOut, burstEn, fieldOut, phaseLead;
  int checks = 0, failures = 0;
  int hM = 0;
  logic fM = 1'b0, pendM = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vsync_gen u_vsync_gen (
    .clk(clk), .rstN(rstN), .halfStrobe(halfStrobe), .hSyncIn(hSyncIn),
    .eqIn(eqIn), .serIn(serIn), .vrIn(vrIn), .blkSel(blkSel),
    .syncOut(syncOut), .vpOut(vpOut), .vBlankOut(vBlankOut),
    .burstEn(burstEn), .fieldOut(fieldOut), .phaseLead(phaseLead)
  );

  // {halfLine[9:0], blkSel[1:0], vp, vBlank, burstEn}, field 0 after reset
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {10'd0,   2'd0, 3'b010}, {10'd5,   2'd0, 3'b010}, {10'd6,   2'd0, 3'b110},
    {10'd11,  2'd0, 3'b110}, {10'd12,  2'd0, 3'b010}, {10'd17,  2'd0, 3'b010},
    {10'd18,  2'd0, 3'b011}, {10'd20,  2'd0, 3'b011}, {10'd21,  2'd0, 3'b011},
    {10'd37,  2'd0, 3'b011}, {10'd38,  2'd0, 3'b001}, {10'd38,  2'd1, 3'b011},
    {10'd40,  2'd1, 3'b001}, {10'd41,  2'd2, 3'b011}, {10'd41,  2'd3, 3'b011},
    {10'd42,  2'd3, 3'b001}
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b (half=%0d field=%0b)", req, act, exp, hM, fM);
    end
  endtask

  task automatic stepHalf();
    @(negedge clk) halfStrobe = 1'b1;
    @(negedge clk) halfStrobe = 1'b0;
    if (pendM) begin
      hM = 6; pendM = 1'b0;
    end else if (hM == 524) begin
      hM = 0; fM = ~fM;
    end else hM++;
    repeat (2) @(negedge clk);
  endtask

  task automatic goTo(int target);
    while (hM != target) stepHalf();
  endtask

  function automatic logic expSync(int h, logic f, logic hs, logic eq, logic sr);
    if (h >= 6 && h < 12) return sr;
    if (h < 18) return eq;
    return (h % 2 == int'(f)) ? hs : 1'b0;
  endfunction

  task automatic checkSync(string req);
    for (int k = 0; k < 3; k++) begin
      hSyncIn = (k == 0); eqIn = (k == 1); serIn = (k == 2);
      #1;
      check(req, syncOut, expSync(hM, fM, hSyncIn, eqIn, serIn));
    end
    hSyncIn = 1'b0; eqIn = 1'b0; serIn = 1'b0;
  endtask

  task automatic vrFall();
    @(negedge clk) vrIn = 1'b0;
    repeat (4) @(negedge clk);
    pendM = 1'b1;
    check("R8 phase", phaseLead, hM < 6);
    vrIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 phase held after rise", phaseLead, hM < 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 vp", vpOut, 1'b0);
    check("R9 vblank", vBlankOut, 1'b1);
    check("R9 burst", burstEn, 1'b0);
    check("R9 field", fieldOut, 1'b0);
    check("R9 phase", phaseLead, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 hold without strobe", vpOut, 1'b0);

    // Vector walk: R2, R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      goTo(int'(VEC[i][14:5]));
      blkSel = VEC[i][4:3];
      #1;
      check("R2 vp", vpOut, VEC[i][2]);
      check("R6 vblank", vBlankOut, VEC[i][1]);
      check("R5 burst", burstEn, VEC[i][0]);
      checkSync("R3/R4 sync");
    end

    // R1 wrap and field toggle
    goTo(524);
    check("R1 field before wrap", fieldOut, 1'b0);
    stepHalf();
    check("R1 field after wrap", fieldOut, 1'b1);
    check("R1 back to eq region", burstEn, 1'b0);

    // R4 line parity in field 1
    goTo(20);
    checkSync("R4 field1 even half");
    goTo(21);
    checkSync("R4 field1 odd half");

    // R7/R8 trailing reset edge
    goTo(100);
    vrFall();
    check("R7 no change before strobe", vpOut, 1'b0);
    stepHalf();
    check("R7 vp after realign", vpOut, 1'b1);
    check("R7 field unchanged", fieldOut, 1'b1);
    stepHalf();
    check("R7 count resumes", vpOut, 1'b1);
    goTo(12);
    check("R7 vp ends at 12", vpOut, 1'b0);

    // R7/R8 leading reset edge in field 0
    goTo(524);
    stepHalf();
    goTo(3);
    vrFall();
    stepHalf();
    check("R7 vp early realign", vpOut, 1'b1);
    check("R7 field0 kept", fieldOut, 1'b0);

    // R9 reset mid-run
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    check("R9 vp in reset", vpOut, 1'b0);
    check("R9 phase cleared", phaseLead, 1'b0);
    check("R9 field cleared", fieldOut, 1'b0);
    check("R9 burst off", burstEn, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule